// File: doc/BRIEF.md
# Write-Only SPI Command/Data Byte Framer

This block turns a stream of bytes from an upstream producer into framed transfers on a write-only SPI link to a display controller. The link has a separate data/command select line (DC) next to the usual clock, data and chip-select wires. Each upstream byte comes with two flags. One says whether the byte is a command or data. The other marks the last byte of a data burst. Bytes are taken through a valid/ready handshake.

A command always travels alone. CS falls, DC is low for the one byte, and CS is released afterwards. Data may be a single byte or a burst. A burst keeps CS low from its first byte to its last. If the producer stalls in the middle of a burst, the block parks with the clock low and CS still asserted. A command that shows up during such a stall first closes the open burst and is then sent in its own frame. The link uses SPI mode 0 and sends the MSB first. A half-period divider sets the SCLK rate from the core clock: SCLK = f_clk / (2 × (cfg_half_div + 1)). With an 80 MHz core clock, settings 1 and 0 give 20 MHz and 40 MHz.

The controller has six states:
- IDLE: CS high, DC high, ready high.
- LEAD: CS low, clock low, the first bit on MOSI.
- HIGH: clock high.
- LOW: clock low, the next bit on MOSI.
- GAP: parked inside a burst, ready for more data.
- TRAIL: clock low, CS still low before release.

The transitions are:
- IDLE→LEAD when a byte is accepted.
- LEAD→HIGH, LOW→HIGH and HIGH→LOW when the half period expires.
- HIGH→TRAIL or HIGH→GAP after the eighth bit, depending on whether the frame ends.
- GAP→LOW when the next data byte is accepted.
- GAP→TRAIL when a command is waiting.
- TRAIL→IDLE when the half period expires.

Top module: `dcspi_framer`

## Requirements
- R1: SCLK idles low. MOSI changes only while SCLK is low. Each byte is sent most significant bit first, and the receiver samples each bit on the rising SCLK edge.
- R2: A byte with `in_is_data`=0 is a command. It is sent alone in its own CS frame with DC low for the whole frame. After it, CS returns high and DC returns high.
- R3: A byte with `in_is_data`=1 and `in_last`=1 that starts a frame is sent alone with DC high, and CS is released after it.
- R4: Data bytes with `in_last`=0 keep CS low. The following data bytes are sent in the same frame until a byte with `in_last`=1 has been sent.
- R5: If the next byte of an open burst is not valid after the current byte ends, SCLK stays low and CS stays low for as long as needed, with `in_ready` high.
- R6: A command that is offered while a burst is open is not accepted at once. The burst frame is closed first, and the command then goes out in a new frame.
- R7: `in_ready` is low while a byte is being shifted. It is high only in IDLE, or in GAP while `in_is_data`=1.
- R8: Each SCLK high phase and each low phase inside a byte lasts `cfg_half_div`+1 core clock cycles.
- R9: The first rising SCLK edge comes `cfg_half_div`+1 cycles after CS falls, with DC already at its final level. CS rises `cfg_half_div`+1 cycles after the last falling SCLK edge.
- R10: After reset, CS is high, DC is high, SCLK is low and `in_ready` is high.
- R11: Whenever CS is high, DC is high, and CS stays high for at least one core cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_div | input | DIV_W | Half-period length in core cycles, minus one; keep it steady during a frame |
| in_valid | input | 1 | Upstream byte is valid |
| in_ready | output | 1 | Framer takes the byte at this edge |
| in_data | input | BYTE_W | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Data byte ends the burst |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | 1 = data, 0 = command |

## Verification
The checker tests these rules on every cycle:
- The clock stays low while CS is high.
- MOSI is held for the whole high phase.
- Ready stays low while the clock is high.
- DC is high whenever CS is high and does not change inside a frame.

Only the bench's scenarios can show the following:
- The decoded byte values and bit order.
- Which bytes share a CS frame, including how a stalled burst closes when a command arrives.
- The exact lead, trail and half-period lengths for a given divider setting.

// File: rtl/dcspi_pkg.sv
package dcspi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_TRAIL
    } fr_state_t;
endpackage

// File: rtl/dcspi_halfper.sv
// Half-period timer: tick marks the last cycle of a phase of limit+1 cycles.
module dcspi_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= limit;
        else
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/dcspi_shifter.sv
// MSB-first output shift register.
module dcspi_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic              mosi
);
    logic [BYTE_W-1:0] sr_q;

    assign mosi = sr_q[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= din;
        else if (shift)
            sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
    end
endmodule

// File: rtl/dcspi_ctrl.sv
// Framing state machine: decides CS, DC, SCLK and the handshake.
module dcspi_ctrl #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic in_valid,
    input  logic in_is_data,
    input  logic in_last,
    output logic in_ready,
    output logic load,
    output logic shift,
    output logic restart,
    output logic sclk,
    output logic cs_n,
    output logic dc
);
    import dcspi_pkg::*;

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(BYTE_W - 1);

    fr_state_t        state_q, state_nx;
    logic [CNT_W-1:0] bits_left_q;
    logic             last_q;
    logic             accept;
    logic             byte_end;

    assign in_ready = (state_q == ST_IDLE) || ((state_q == ST_GAP) && in_is_data);
    assign accept   = in_valid && in_ready;
    assign byte_end = (state_q == ST_HIGH) && tick && (bits_left_q == '0);
    assign shift    = (state_q == ST_HIGH) && tick && (bits_left_q != '0);
    assign load     = accept;
    assign restart  = (state_nx != state_q);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_nx = ST_LEAD;
            ST_LEAD:  if (tick) state_nx = ST_HIGH;
            ST_HIGH:  begin
                if (byte_end)  state_nx = last_q ? ST_TRAIL : ST_GAP;
                else if (tick) state_nx = ST_LOW;
            end
            ST_LOW:   if (tick) state_nx = ST_HIGH;
            ST_GAP:   begin
                if (accept)                       state_nx = ST_LOW;
                else if (in_valid && !in_is_data) state_nx = ST_TRAIL;
            end
            ST_TRAIL: if (tick) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register with byte bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
            last_q      <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                bits_left_q <= TOP_BIT;
                last_q      <= in_last || !in_is_data;
            end else if (shift) begin
                bits_left_q <= bits_left_q - 1'b1;
            end
        end
    end

    // registered link outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            cs_n <= 1'b1;
            dc   <= 1'b1;
        end else begin
            sclk <= (state_nx == ST_HIGH);
            cs_n <= (state_nx == ST_IDLE);
            if (state_nx == ST_IDLE)
                dc <= 1'b1;
            else if (accept && (state_q == ST_IDLE))
                dc <= in_is_data;
        end
    end
endmodule

// File: rtl/dcspi_framer.sv
module dcspi_framer #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_is_data,
    input  logic              in_last,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              spi_dc
);
    logic tick, restart, load, shift;

    dcspi_halfper #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (cfg_half_div),
        .tick    (tick)
    );

    dcspi_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (in_data),
        .mosi  (spi_mosi)
    );

    dcspi_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .in_valid   (in_valid),
        .in_is_data (in_is_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .load       (load),
        .shift      (shift),
        .restart    (restart),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .dc         (spi_dc)
    );
endmodule

// File: rtl/dcspi_framer_chk.sv
module dcspi_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_dc
);
    // R1: clock parked low outside a frame
    a_r1_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R1: data held through the high phase
    a_r1_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R7: no handshake while a bit is on the wire
    a_r7_ready_low_shift: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !in_ready);

    // R11: select idles at data level
    a_r11_dc_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_dc);

    // R2: DC does not move inside a frame
    a_r2_dc_steady_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$past(spi_cs_n)) |-> $stable(spi_dc));

    // R9: no rising edge in the cycle CS falls
    a_r9_no_edge_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);
endmodule

bind dcspi_framer dcspi_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .spi_dc   (spi_dc)
);

// File: tb/test_dcspi_framer.sv
`timescale 1ns/1ps
module test_dcspi_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_half_div = 8'd1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b1;
    logic       in_last = 1'b1;
    logic       spi_sclk, spi_mosi, spi_cs_n, spi_dc;

    always #2.5 clk = ~clk;

    dcspi_framer i_dcspi_framer (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_is_data(in_is_data), .in_last(in_last),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    int checks = 0;
    int fails  = 0;

    // expected byte log
    logic [7:0] exp_b [0:63];
    logic       exp_dc[0:63];
    int         exp_f [0:63];
    int         nexp = 0;
    int         efid = 0;
    bit         open_burst = 0;

    // observed byte log
    logic [7:0] got_b [0:63];
    logic       got_dc[0:63];
    int         got_f [0:63];
    int         ngot = 0;

    // monitor state
    int   mfid = 0, bitcnt = 0;
    logic [7:0] sh = '0;
    logic prev_sclk = 0, prev_cs = 1, prev_mosi = 0, first_rise = 0;
    int   lead_cnt = 0, lead_len = 0, hw_cnt = 0, hw_len = 0, tr_cnt = 0, tr_len = 0;
    int   v_ready = 0, v_mosi = 0, v_dc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sclk && in_ready) v_ready++;
            if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) v_mosi++;
            if (spi_cs_n && !spi_dc) v_dc++;
            if (!spi_cs_n && prev_cs) begin lead_cnt = 0; first_rise = 1; end
            else lead_cnt++;
            if (spi_sclk && !prev_sclk) begin
                if (first_rise) begin lead_len = lead_cnt; first_rise = 0; end
                hw_cnt = 0;
                sh = {sh[6:0], spi_mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (ngot < 64) begin
                        got_b[ngot] = sh; got_dc[ngot] = spi_dc; got_f[ngot] = mfid;
                    end
                    ngot++;
                    bitcnt = 0;
                end
            end
            if (spi_sclk) hw_cnt++;
            if (!spi_sclk && prev_sclk) begin hw_len = hw_cnt; tr_cnt = 0; end
            else tr_cnt++;
            if (spi_cs_n && !prev_cs) begin tr_len = tr_cnt; mfid++; end
            prev_sclk = spi_sclk; prev_cs = spi_cs_n; prev_mosi = spi_mosi;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic send(input logic isd, input logic lst, input logic [7:0] gap, input logic [7:0] d);
        repeat (gap) @(negedge clk);
        if (!isd && open_burst) efid++;
        exp_b[nexp] = d; exp_dc[nexp] = isd; exp_f[nexp] = efid; nexp++;
        if (!isd || lst) begin efid++; open_burst = 0; end
        else open_burst = 1;
        in_valid = 1; in_is_data = isd; in_last = lst; in_data = d;
        forever begin
            #1;
            if (in_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        in_valid = 0; in_is_data = 1; in_last = 1;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (!spi_cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // {is_data, last, gap[7:0], data[7:0]}
    localparam logic [17:0] VEC [0:11] = '{
        {1'b0, 1'b1, 8'd0,  8'h12},
        {1'b1, 1'b1, 8'd3,  8'hA5},
        {1'b0, 1'b1, 8'd0,  8'h44},
        {1'b1, 1'b0, 8'd0,  8'h01},
        {1'b1, 1'b0, 8'd0,  8'h80},
        {1'b1, 1'b1, 8'd0,  8'h3C},
        {1'b0, 1'b1, 8'd2,  8'h24},
        {1'b1, 1'b0, 8'd0,  8'hFF},
        {1'b1, 1'b0, 8'd20, 8'h00},
        {1'b1, 1'b0, 8'd0,  8'h5A},
        {1'b0, 1'b1, 8'd4,  8'h20},
        {1'b1, 1'b1, 8'd0,  8'hC3}
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog R5 run hung actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(spi_cs_n && spi_dc && !spi_sclk && in_ready, "R10 reset outputs",
            {spi_cs_n, spi_dc, spi_sclk, in_ready}, 4'b1101);

        // table: R1 R2 R3 R4 R5 R6 with cfg 1
        foreach (VEC[i]) send(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
        wait_idle();

        // R8 R9: timing with cfg 2
        cfg_half_div = 8'd2;
        send(1'b1, 1'b1, 0, 8'h96);
        wait_idle();
        chk(hw_len == 3, "R8 high phase cfg2", hw_len, 3);
        chk(lead_len == 3, "R9 lead cfg2", lead_len, 3);
        chk(tr_len == 3, "R9 trail cfg2", tr_len, 3);

        // R5: parked burst
        send(1'b1, 1'b0, 0, 8'h11);
        repeat (100) @(negedge clk);
        chk(!spi_cs_n && !spi_sclk && in_ready, "R5 parked cs/sclk/ready",
            {spi_cs_n, spi_sclk, in_ready}, 3'b001);
        send(1'b1, 1'b1, 0, 8'h22);
        wait_idle();

        // R8: fastest divider with a command
        cfg_half_div = 8'd0;
        send(1'b0, 1'b1, 0, 8'hE7);
        wait_idle();
        chk(hw_len == 1, "R8 high phase cfg0", hw_len, 1);
        chk(lead_len == 1, "R9 lead cfg0", lead_len, 1);

        // R7 R1 R11: cycle-level violation counts
        chk(v_ready == 0, "R7 ready high while shifting", v_ready, 0);
        chk(v_mosi == 0, "R1 mosi moved with sclk high", v_mosi, 0);
        chk(v_dc == 0, "R11 dc low with cs high", v_dc, 0);
        chk(spi_dc && spi_cs_n, "R2 dc back high after command", {spi_cs_n, spi_dc}, 2'b11);

        // R1 R2 R3 R4 R6: byte values, DC level and framing
        chk(ngot == nexp, "R4 byte count", ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++)
            chk(got_b[i] == exp_b[i] && got_dc[i] == exp_dc[i] && got_f[i] == exp_f[i],
                $sformatf("R1/R2/R3/R4/R6 byte %0d {frame,dc,byte}", i),
                (got_f[i] << 9) | (int'(got_dc[i]) << 8) | int'(got_b[i]),
                (exp_f[i] << 9) | (int'(exp_dc[i]) << 8) | int'(exp_b[i]));

        summary();
        $finish;
    end
endmodule